// File: doc/BRIEF.md
# Averaging Rate Reducer for Mono Audio

This block turns a fast stream of 16-bit signed mono audio samples into a slow one by plain averaging. On the producer clock it adds up every sample it receives. When a slower consumer, running on its own unrelated clock, asks for an output sample, the running total and the number of samples in it are frozen. A fresh total is then started with the sample of that same cycle. The frozen total is divided by its count, and the mean is delivered to the consumer.

The consumer issues a one-cycle request and waits. Its busy flag stays high until a one-cycle valid pulse presents the new mean, and the value then holds until the next delivery. The request reaches the producer as a toggle through a two-stage synchronizer, and the completion returns the same way. The result register never changes while a transfer is in flight. With a producer near 1.79 MHz and a consumer asking at 48 kHz, each window holds about 37 or 38 samples.

Top module: `avg_decimator`

## Requirements
- R1: A sample on `p_sample` (16-bit two's complement) is taken into the running window on each producer rising edge where `p_valid` is high. Edges with `p_valid` low add nothing and are not counted.
- R2: A consumer rising edge with `c_req` high and `c_busy` low accepts a request. From the next cycle `c_busy` is high, and it stays high until the cycle in which `c_valid` is high.
- R3: `c_req` on an edge where `c_busy` is high is ignored: it causes no extra delivery and no window boundary.
- R4: The delivered value is the sum of the window's samples divided by their count, truncated toward zero.
- R5: A window closes on the third producer rising edge after the consumer edge that accepted the request. A sample taken on that closing edge is the first sample of the next window, so no sample is lost or counted twice.
- R6: A window with a count of zero delivers the previous result again. The result is 0 if nothing has been delivered since reset.
- R7: `c_valid` is high for exactly one consumer cycle per delivery. `c_sample` changes only in that cycle and holds its value otherwise.
- R8: `c_valid` rises no later than (3 + ACC_W) producer periods plus 4 consumer periods after the accepting edge.
- R9: After reset, `c_busy`, `c_valid` and `c_sample` are all zero.
- R10: Windows of up to 63 full-scale samples (all 32767, all -32768, or alternating between them) give exact means with no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| p_clk | input | 1 | Producer clock |
| p_rst_n | input | 1 | Producer reset, asynchronous, active low |
| p_valid | input | 1 | Sample present this producer cycle |
| p_sample | input | SAMPLE_W | Signed input sample |
| c_clk | input | 1 | Consumer clock |
| c_rst_n | input | 1 | Consumer reset, asynchronous, active low |
| c_req | input | 1 | Request for one averaged sample |
| c_busy | output | 1 | Request outstanding |
| c_valid | output | 1 | One-cycle pulse: new mean on c_sample |
| c_sample | output | SAMPLE_W | Averaged output sample |

## Verification
The window boundary falls on the third producer edge after acceptance. The bench's reference model reproduces that count from its own copy of the request times and pushes the expected mean on exactly that edge. The mean then needs ACC_W producer cycles for the division and three consumer edges for the return path. Because that arrival time is not fixed, the bench compares the value whenever `c_valid` is seen. It bounds the arrival time against R8 and checks on every other consumer cycle that `c_sample` has held. `c_busy` is checked one consumer cycle after each accepted request. Stray requests are injected only while busy is high, and the bench confirms that they produce no extra deliveries.

// File: rtl/avg_decimator.sv
`timescale 1ns/1ps
module avg_decimator #(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 6,
  parameter int ACC_W    = SAMPLE_W + CNT_W
) (
  input  logic                p_clk,
  input  logic                p_rst_n,
  input  logic                p_valid,
  input  logic [SAMPLE_W-1:0] p_sample,
  input  logic                c_clk,
  input  logic                c_rst_n,
  input  logic                c_req,
  output logic                c_busy,
  output logic                c_valid,
  output logic [SAMPLE_W-1:0] c_sample
);
  localparam int STEP_W = $clog2(ACC_W + 1);

  logic                req_tgl;
  logic [2:0]          req_sy;
  logic [2:0]          ack_sy;
  logic                ack_tgl;
  logic [SAMPLE_W-1:0] result;
  logic                take;

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] in_ext;
  logic [CNT_W-1:0]        cnt;

  logic              div_run;
  logic              neg;
  logic [STEP_W-1:0] step;
  logic [ACC_W-1:0]  quo;
  logic [ACC_W-1:0]  q_nx;
  logic [CNT_W-1:0]  dvs;
  logic [CNT_W-1:0]  rem;
  logic [CNT_W-1:0]  rem_nx;
  logic [CNT_W:0]    part;
  logic              ge;

  assign in_ext = {{(ACC_W-SAMPLE_W){p_sample[SAMPLE_W-1]}}, p_sample};
  assign take   = req_sy[1] ^ req_sy[2];
  assign part   = {rem, quo[ACC_W-1]};
  assign ge     = part >= {1'b0, dvs};
  assign rem_nx = ge ? CNT_W'(part - {1'b0, dvs}) : part[CNT_W-1:0];
  assign q_nx   = {quo[ACC_W-2:0], ge};

  always_ff @(posedge p_clk or negedge p_rst_n) begin
    if (!p_rst_n) begin
      req_sy  <= '0;
      acc     <= '0;
      cnt     <= '0;
      div_run <= 1'b0;
      neg     <= 1'b0;
      step    <= '0;
      quo     <= '0;
      dvs     <= '0;
      rem     <= '0;
      result  <= '0;
      ack_tgl <= 1'b0;
    end else begin
      req_sy <= {req_sy[1:0], req_tgl};
      if (take) begin
        acc <= p_valid ? in_ext : '0;
        cnt <= p_valid ? CNT_W'(1) : '0;
        if (cnt == '0) begin
          ack_tgl <= ~ack_tgl;
        end else begin
          div_run <= 1'b1;
          step    <= '0;
          neg     <= acc[ACC_W-1];
          quo     <= acc[ACC_W-1] ? -acc : acc;
          dvs     <= cnt;
          rem     <= '0;
        end
      end else if (p_valid) begin
        acc <= acc + in_ext;
        cnt <= cnt + 1'b1;
      end
      if (div_run) begin
        quo  <= q_nx;
        rem  <= rem_nx;
        step <= step + 1'b1;
        if (step == STEP_W'(ACC_W - 1)) begin
          div_run <= 1'b0;
          result  <= neg ? -q_nx[SAMPLE_W-1:0] : q_nx[SAMPLE_W-1:0];
          ack_tgl <= ~ack_tgl;
        end
      end
    end
  end

  assign c_busy = req_tgl ^ ack_sy[2];

  always_ff @(posedge c_clk or negedge c_rst_n) begin
    if (!c_rst_n) begin
      req_tgl  <= 1'b0;
      ack_sy   <= '0;
      c_valid  <= 1'b0;
      c_sample <= '0;
    end else begin
      ack_sy  <= {ack_sy[1:0], ack_tgl};
      c_valid <= ack_sy[1] ^ ack_sy[2];
      if (ack_sy[1] ^ ack_sy[2]) c_sample <= result;
      if (c_req && !c_busy) req_tgl <= ~req_tgl;
    end
  end

  // R3
  take_idle_chk: assert property (@(posedge p_clk) disable iff (!p_rst_n)
    take |-> !div_run);

  // R6
  zero_cnt_chk: assert property (@(posedge p_clk) disable iff (!p_rst_n)
    (take && cnt == '0) |=> $stable(result));

  // R7
  valid_pulse_chk: assert property (@(posedge c_clk) disable iff (!c_rst_n)
    c_valid |=> !c_valid);

  // R7
  hold_chk: assert property (@(posedge c_clk) disable iff (!c_rst_n)
    !c_valid |-> $stable(c_sample));

  // R2
  busy_release_chk: assert property (@(posedge c_clk) disable iff (!c_rst_n)
    $fell(c_busy) |-> c_valid);
endmodule

// File: tb/sim_avg_decimator.sv
`timescale 1ns/1ps
module sim_avg_decimator;
  localparam realtime P_PER = 10.0;
  localparam realtime C_PER = 37.3;
  localparam int SW = 16;
  localparam int CW = 6;
  localparam int AW = 22;
  localparam realtime BOUND = (3 + AW) * P_PER + 4 * C_PER;

  logic p_clk = 0, c_clk = 0;
  logic p_rst_n = 0, c_rst_n = 0;
  logic p_valid = 0, c_req = 0;
  logic [SW-1:0] p_sample = '0;
  logic c_busy, c_valid;
  logic [SW-1:0] c_sample;

  avg_decimator #(.SAMPLE_W(SW), .CNT_W(CW), .ACC_W(AW)) u0 (
    .p_clk(p_clk), .p_rst_n(p_rst_n), .p_valid(p_valid), .p_sample(p_sample),
    .c_clk(c_clk), .c_rst_n(c_rst_n), .c_req(c_req),
    .c_busy(c_busy), .c_valid(c_valid), .c_sample(c_sample));

  always #(P_PER/2) p_clk = ~p_clk;
  initial begin
    #0.123;
    forever #(C_PER/2) c_clk = ~c_clk;
  end

  int checks = 0, fails = 0;
  int phase = 0, ramp = 0, accepted = 0, delivered = 0;
  bit alt = 0, tb_tgl = 0, acc_pending = 0, q1 = 0, q2 = 0, q3 = 0, done = 0;
  int macc = 0, mcnt = 0, last_exp = 0;
  int exp_q[$];
  string tag_q[$];
  realtime t_acc = 0;
  logic [SW-1:0] last_out = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // stimulus on the producer side; R1 gating in phase 5, R10 extremes in 3, 6, 8
  always @(negedge p_clk) begin
    ramp = ramp + 977;
    alt  = ~alt;
    p_valid = 1;
    case (phase)
      0, 7: begin p_valid = 0; p_sample = 16'h1234; end
      1: p_sample = 16'd1000;
      2: p_sample = ramp[15:0];
      3: p_sample = alt ? 16'h7FFF : 16'h8000;
      4: p_sample = 16'($urandom);
      5: begin p_valid = ($urandom % 3) != 0; p_sample = 16'($urandom); end
      6: p_sample = 16'h8000;
      default: p_sample = 16'h7FFF;
    endcase
  end

  // reference model: window closes three producer edges after acceptance (R5)
  always @(posedge p_clk) begin
    if (!p_rst_n) begin
      q1 = 0; q2 = 0; q3 = 0; macc = 0; mcnt = 0;
    end else begin
      bit bnd;
      int e;
      string t;
      bnd = (q2 != q3);
      q3 = q2; q2 = q1; q1 = tb_tgl;
      if (bnd) begin
        if (mcnt == 0) begin e = last_exp; t = "R6"; end
        else begin
          e = macc / mcnt;
          if (phase == 3 || phase == 6 || phase == 8) t = "R10";
          else if (phase == 5) t = "R1";
          else t = "R4 R5";
        end
        last_exp = e;
        exp_q.push_back(e);
        tag_q.push_back(t);
        macc = p_valid ? int'($signed(p_sample)) : 0;
        mcnt = p_valid ? 1 : 0;
      end else if (p_valid) begin
        macc += int'($signed(p_sample));
        mcnt++;
      end
    end
  end

  always @(posedge c_clk) begin
    if (acc_pending) begin
      tb_tgl = ~tb_tgl;
      acc_pending = 0;
      t_acc = $realtime;
    end
  end

  // every consumer cycle: delivery value and latency, or hold (R7, R8)
  always @(negedge c_clk) begin
    if (c_rst_n && !done) begin
      if (c_valid) begin
        delivered++;
        if (exp_q.size() == 0) begin
          chk(0, "R3 extra delivery", int'($signed(c_sample)), 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(int'($signed(c_sample)) == e, t, int'($signed(c_sample)), e);
          chk(($realtime - t_acc) <= BOUND, "R8 latency ns",
              int'($realtime - t_acc), int'(BOUND));
        end
      end else begin
        chk(c_sample == last_out, "R7 hold", int'(c_sample), int'(last_out));
      end
      last_out = c_sample;
    end
  end

  task automatic do_req(input int gap, input bit spur);
    while (c_busy) @(negedge c_clk);
    repeat (gap) @(negedge c_clk);
    c_req = 1;
    acc_pending = 1;
    accepted++;
    @(negedge c_clk);
    chk(c_busy == 1, "R2 busy", int'(c_busy), 1);
    c_req = spur;
    @(negedge c_clk);
    c_req = 0;
  endtask

  initial begin
    repeat (3) @(negedge p_clk);
    p_rst_n = 1;
    @(negedge c_clk);
    c_rst_n = 1;
    chk(c_busy == 0 && c_valid == 0 && c_sample == 0, "R9 reset",
        int'({c_busy, c_valid, c_sample}), 0);
    repeat (4) @(negedge c_clk);
    do_req(0, 0);
    for (int ph = 1; ph <= 8; ph++) begin
      if (ph == 7) continue;
      phase = ph;
      for (int k = 0; k < 7; k++) do_req(k % 3, k[0]);
    end
    phase = 4;
    do_req(1, 0);
    do_req(0, 1);
    phase = 7;
    do_req(0, 0);
    do_req(0, 0);
    do_req(2, 1);
    phase = 2;
    do_req(0, 0);
    while (c_busy) @(negedge c_clk);
    repeat (4) @(negedge c_clk);
    done = 1;
    chk(delivered == accepted, "R3 deliveries", delivered, accepted);
    chk(exp_q.size() == 0, "R5 windows closed", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    #(P_PER * 200000);
    checks++;
    fails++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", delivered, accepted);
    finish_run();
  end
endmodule